// File: doc/BRIEF.md
# Radix-4 Booth Sequential Multiplier

This block multiplies two signed two's-complement operands of `N` bits over several clock cycles and returns their full `2N`-bit product. A one-cycle `start` pulse, taken while the unit is idle, captures both operands. Each working cycle then retires two bits of the multiplier. For each pair of bits the unit reads an overlapping three-bit window of the multiplier and adds one of five terms to an accumulator: zero, plus or minus the multiplicand, or plus or minus twice the multiplicand. It then shifts the accumulator and the multiplier register together two places to the right, with sign extension. Because of this recoding, runs of ones in the multiplier cost no additions.

The multiplier window has an implicit zero below its least significant bit, and the accumulator carries two guard bits. Because of this, every operand pair is exact, including those involving the most negative value. At the end of the run the product is copied into an output register and `done` pulses for one cycle. The product then stays unchanged until the next operation finishes. `N` must be even.

Top module: `booth_mul_seq`

## Requirements
- R1: While reset is high and on the first cycle after reset, `done` is 0 and `product` is all zeros.
- R2: A `start` seen high at a rising edge while the unit is idle captures `op_a` (multiplicand) and `op_b` (multiplier). The operation's `product` equals the exact signed product op_a × op_b as a `2N`-bit two's-complement value.
- R3: `done` first goes high N/2+1 rising edges after the edge that captured `start`. It stays high for exactly one cycle, and `product` holds the new result while `done` is high.
- R4: Between completions, `product` keeps the value of the last completed operation, and `done` stays low.
- R5: `start` pulses and changes to `op_a`/`op_b` that occur while an operation is in progress have no effect on that operation's result or timing.
- R6: Operands at the extremes of the range give exact products. This covers -2^(N-1) × -2^(N-1) = 2^(2N-2), -2^(N-1) × (2^(N-1)-1), and -1 × -1.
- R7: Each multiplier window {b[2i+1], b[2i], b[2i-1]} (with b[-1]=0) selects an accumulator term. The windows 000 and 111 add 0, 001 and 010 add +A, 011 adds +2A, 100 adds -2A, and 101 and 110 add -A. Multipliers made of a repeated window, such as 0x5555 (010 throughout) and 0xAAAA (100 then 101), give exact products.
- R8: A `start` given in the cycle that `done` is high is accepted. Its result follows after the same latency as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (taken only when idle) |
| op_a | input | N | Multiplicand, two's complement |
| op_b | input | N | Multiplier, two's complement |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2N | Signed product, held until the next completion |

## Verification
A wrong recoding entry or a missing guard bit in the accumulator shows up only as a wrong `product`. This happens at the `done` pulse of any operation whose multiplier contains that window, or whose partial sum reaches ±2A. Directed repeated-window multipliers and extreme operands therefore expose each table row within one operation. A miscounted iteration shows as `done` arriving earlier or later than N/2+1 edges. It also shows as a product scaled by a power of four, visible at the first completion. A controller that re-accepts `start` while busy changes both the latency and the result of the operation in flight.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Term that a recoded multiplier window adds into the accumulator.
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_P1   = 3'd1,
    OP_P2   = 3'd2,
    OP_M1   = 3'd3,
    OP_M2   = 3'd4
  } booth_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_OUT  = 2'd2
  } booth_state_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic [2:0] window,
  output booth_op_e  op
);

  // R7: radix-4 recoding of the overlapping window {b(2i+1), b(2i), b(2i-1)}
  always_comb begin
    unique case (window)
      3'b001, 3'b010: op = OP_P1;
      3'b011:         op = OP_P2;
      3'b100:         op = OP_M2;
      3'b101, 3'b110: op = OP_M1;
      default:        op = OP_NONE;
    endcase
  end

endmodule

// File: rtl/booth_addend.sv
module booth_addend
  import booth_pkg::*;
#(
  parameter int N     = 16,
  parameter int ACC_W = N + 2
) (
  input  logic [N-1:0]     mcand,
  input  booth_op_e        op,
  output logic [ACC_W-1:0] addend
);

  localparam int EXT1 = ACC_W - N;
  localparam int EXT2 = ACC_W - N - 1;

  logic [ACC_W-1:0] m1;
  logic [ACC_W-1:0] m2;

  // Sign-extended multiplicand and its doubled form
  assign m1 = {{EXT1{mcand[N-1]}}, mcand};
  assign m2 = {{EXT2{mcand[N-1]}}, mcand, 1'b0};

  always_comb begin
    unique case (op)
      OP_P1:   addend = m1;
      OP_P2:   addend = m2;
      OP_M1:   addend = ~m1 + 1'b1;
      OP_M2:   addend = ~m2 + 1'b1;
      default: addend = '0;
    endcase
  end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy
);

  localparam int STEPS = N / 2;
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

  booth_state_e     state;
  logic [CNT_W-1:0] cnt;

  assign busy   = (state != ST_IDLE);
  assign load   = (state == ST_IDLE) && start;
  assign step   = (state == ST_STEP);
  assign finish = (state == ST_OUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_STEP;
            cnt   <= '0;
          end
        end
        ST_STEP: begin
          if (cnt == LAST) state <= ST_OUT;
          else             cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/booth_dp.sv
module booth_dp #(
  parameter int N     = 16,
  parameter int ACC_W = N + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [N-1:0]     a_in,
  input  logic [N-1:0]     b_in,
  input  logic [ACC_W-1:0] addend,
  output logic [2:0]       window,
  output logic [N-1:0]     mcand,
  output logic [N-1:0]     acc_lo,
  output logic [N-1:0]     mplr
);

  logic [ACC_W-1:0] acc;
  logic             guard;
  logic [ACC_W-1:0] sum;

  assign sum    = acc + addend;
  assign window = {mplr[1:0], guard};
  assign acc_lo = acc[N-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      mplr  <= '0;
      guard <= 1'b0;
      mcand <= '0;
    end else if (load) begin
      acc   <= '0;
      mplr  <= b_in;
      guard <= 1'b0;
      mcand <= a_in;
    end else if (step) begin
      // Arithmetic right shift by two of the {sum, mplr, guard} chain
      acc   <= {{2{sum[ACC_W-1]}}, sum[ACC_W-1:2]};
      mplr  <= {sum[1:0], mplr[N-1:2]};
      guard <= mplr[1];
    end
  end

endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
  import booth_pkg::*;
#(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   op_a,
  input  logic [N-1:0]   op_b,
  output logic           done,
  output logic [2*N-1:0] product
);

  localparam int ACC_W = N + 2;

  logic             load;
  logic             step;
  logic             finish;
  logic             busy;
  logic [2:0]       window;
  booth_op_e        op;
  logic [N-1:0]     mcand;
  logic [N-1:0]     acc_lo;
  logic [N-1:0]     mplr;
  logic [ACC_W-1:0] addend;

  booth_ctrl #(.N(N)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .load   (load),
    .step   (step),
    .finish (finish),
    .busy   (busy)
  );

  booth_recode u_recode (
    .window (window),
    .op     (op)
  );

  booth_addend #(.N(N), .ACC_W(ACC_W)) u_addend (
    .mcand  (mcand),
    .op     (op),
    .addend (addend)
  );

  booth_dp #(.N(N), .ACC_W(ACC_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .step   (step),
    .a_in   (op_a),
    .b_in   (op_b),
    .addend (addend),
    .window (window),
    .mcand  (mcand),
    .acc_lo (acc_lo),
    .mplr   (mplr)
  );

  // Registered result and completion pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      product <= '0;
    end else begin
      done <= finish;
      if (finish) product <= {acc_lo, mplr};
    end
  end

endmodule

// File: rtl/booth_mul_seq_chk.sv
module booth_mul_seq_chk #(
  parameter int N = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           busy,
  input logic [N-1:0]   op_a,
  input logic [N-1:0]   op_b,
  input logic           done,
  input logic [2*N-1:0] product
);

  localparam int LAT = N / 2 + 1;

  logic        tracking;
  logic [15:0] run_cnt;
  logic        sa_cap;
  logic        sb_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      tracking <= 1'b0;
      run_cnt  <= '0;
      sa_cap   <= 1'b0;
      sb_cap   <= 1'b0;
    end else if (start && !busy) begin
      tracking <= 1'b1;
      run_cnt  <= '0;
      sa_cap   <= op_a[N-1];
      sb_cap   <= op_b[N-1];
    end else if (done) begin
      tracking <= 1'b0;
    end else if (tracking) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R1: cleared outputs right after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!done && product == '0));

  // R3: completion comes exactly LAT edges after the accepting edge
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (tracking && run_cnt == 16'(LAT)));

  // R3: one-cycle pulse
  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: result held between completions
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));

  // R2: nonzero product sign follows operand signs
  p_sign_r2: assert property (@(posedge clk) disable iff (rst)
    (done && product != '0) |-> (product[2*N-1] == (sa_cap ^ sb_cap)));

endmodule

bind booth_mul_seq booth_mul_seq_chk #(.N(N)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .op_a    (op_a),
  .op_b    (op_b),
  .done    (done),
  .product (product)
);

// File: tb/booth_mul_seq_tb.sv
module booth_mul_seq_tb;

  localparam int N       = 16;
  localparam int LAT     = N / 2 + 1;
  localparam int CLK_PER = 10;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [N-1:0]   op_a = '0;
  logic [N-1:0]   op_b = '0;
  logic           done;
  logic [2*N-1:0] product;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PER / 2) clk = ~clk;

  booth_mul_seq #(.N(N)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .done    (done),
    .product (product)
  );

  function automatic logic [2*N-1:0] ref_mul(logic [N-1:0] a, logic [N-1:0] b);
    logic signed [2*N-1:0] sa;
    logic signed [2*N-1:0] sb;
    logic signed [2*N-1:0] p;
    sa = $signed(a);
    sb = $signed(b);
    p  = sa * sb;
    return p;
  endfunction

  task automatic check(bit ok, string req, string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s", req, msg);
    end
  endtask

  // Called at a negedge; issues start and waits for done at a negedge.
  // When disturb is set, a second start and new operands are applied mid-run.
  task automatic run_op(logic [N-1:0] a, logic [N-1:0] b, string req, bit disturb);
    int idx;
    logic [2*N-1:0] exp_p;
    exp_p = ref_mul(a, b);
    op_a  = a;
    op_b  = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op_a  = ~a;
    op_b  = b + 1'b1;
    idx   = 0;
    while (!done && idx < LAT + 20) begin
      @(negedge clk);
      idx++;
      if (disturb && idx == 2) begin
        start = 1'b1;
        op_a  = a ^ 16'h1234;
        op_b  = b ^ 16'h00F0;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    check(idx == LAT, "R3", $sformatf("latency actual=%0d expected=%0d", idx, LAT));
    check(product == exp_p, req,
          $sformatf("a=%h b=%h actual=%h expected=%h", a, b, product, exp_p));
  endtask

  // R4: no pulse and unchanged product for cycles after completion
  task automatic check_hold(int cycles);
    logic [2*N-1:0] held;
    held = product;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check(!done && product == held, "R4",
            $sformatf("done=%0b product actual=%h expected=%h", done, product, held));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4091));
    repeat (3) @(negedge clk);
    check(!done && product == '0, "R1",
          $sformatf("in reset done=%0b product actual=%h expected=0", done, product));
    rst = 1'b0;
    @(negedge clk);
    check(!done && product == '0, "R1",
          $sformatf("after reset done=%0b product actual=%h expected=0", done, product));

    // R2 basic values
    run_op(16'd3, 16'd7, "R2", 1'b0);
    check_hold(3);
    run_op(16'hFFFB, 16'd11, "R2", 1'b0);
    @(negedge clk);
    run_op(16'd0, 16'h8000, "R2", 1'b0);
    @(negedge clk);

    // R6 extremes
    run_op(16'h8000, 16'h8000, "R6", 1'b0);
    @(negedge clk);
    run_op(16'h8000, 16'h7FFF, "R6", 1'b0);
    @(negedge clk);
    run_op(16'h7FFF, 16'h8000, "R6", 1'b0);
    @(negedge clk);
    run_op(16'hFFFF, 16'hFFFF, "R6", 1'b0);
    @(negedge clk);
    run_op(16'h7FFF, 16'h7FFF, "R6", 1'b0);
    @(negedge clk);

    // R7 repeated-window multipliers
    run_op(16'h1357, 16'h5555, "R7", 1'b0);
    @(negedge clk);
    run_op(16'h8001, 16'hAAAA, "R7", 1'b0);
    @(negedge clk);
    run_op(16'hC3A5, 16'h3333, "R7", 1'b0);
    @(negedge clk);
    run_op(16'h7001, 16'hCCCC, "R7", 1'b0);
    @(negedge clk);
    run_op(16'h0F0F, 16'h6666, "R7", 1'b0);
    check_hold(2);

    // R5 disturbance while busy
    run_op(16'h4321, 16'hBEEF, "R5", 1'b1);
    check_hold(2);
    run_op(16'h8000, 16'h8001, "R5", 1'b1);
    @(negedge clk);

    // R8 back-to-back: start on the done cycle
    run_op(16'h0101, 16'hF00F, "R8", 1'b0);
    run_op(16'hFEDC, 16'h0123, "R8", 1'b0);
    run_op(16'h8000, 16'hFFFF, "R8", 1'b0);
    check_hold(1);

    // R2 constrained random mix
    for (int k = 0; k < 300; k++) begin
      logic [N-1:0] ra;
      logic [N-1:0] rb;
      ra = N'($urandom);
      rb = N'($urandom);
      if (k % 7 == 0) ra = {1'b1, {(N-1){1'b0}}};
      if (k % 11 == 0) rb = {N{1'b1}};
      run_op(ra, rb, "R2", 1'b0);
      if (k % 3 == 0) @(negedge clk);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule